// File: doc/BRIEF.md
# Dual DAC Register Interface with Deferred Load

This block is a byte-wide register file behind a simple synchronous host bus. It serves two 16-bit DAC channels and one 8-bit digital port inside an eight-offset window. The host writes each DAC code in two pieces, a low byte and a high byte, into holding registers. The holding values then move to the output registers that drive the converters. The converters themselves sit outside the block.

A configuration input selects which event performs that move. In per-channel mode, writing a channel's high byte loads that channel's output. In grouped mode, any bus read inside the window loads both channels in the same clock edge. This lets software update both analog outputs at the same instant. The block also holds a latched 8-bit digital output and returns the live level of eight digital input pins. The output code is offset binary: 0x0000 is negative full scale, 0x8000 is mid-scale, and 0xFFFF is one LSB below positive full scale.

Top module: `dual_dac_bus_regs`

## Requirements
- R1: After reset is released, `dac0_o`, `dac1_o` and `dout_o` are all 0x0000/0x00, and so are the holding registers.
- R2: A write to a low-byte offset (4 for channel 0, 6 for channel 1) updates only that channel's holding bits [7:0]. It never changes `dac0_o` or `dac1_o`.
- R3: With `sim_mode_i` = 0 during the write, a write of byte H to a high-byte offset (5 for channel 0, 7 for channel 1) makes that channel's output equal {H, most recent low byte} from the next clock edge. The other channel's output is unchanged.
- R4: With `sim_mode_i` = 1 during the write, a high-byte write only updates the holding bits [15:8]. Neither output changes.
- R5: With `sim_mode_i` = 1, each clock cycle with `rd_i` high at any offset 0..7 copies both channels' holding values into their outputs at that clock edge.
- R6: With `sim_mode_i` = 0, reads change neither DAC output.
- R7: A write to offset 3 sets `dout_o` to the written byte from the next clock edge. `dout_o` keeps that value until the next write to offset 3. Writes to other offsets leave it unchanged.
- R8: While `rd_i` is high with offset 3, `rdata_o` equals `din_i` in the same cycle, following it combinationally. No input value is stored.
- R9: A read of any offset other than 3 returns 0x00. This includes the write-only DAC offsets 4..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Offset within the window |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the strobe cycle |
| sim_mode_i | input | 1 | 0 = per-channel load on high-byte write, 1 = grouped load on read |
| din_i | input | 8 | Digital input pins |
| dout_o | output | 8 | Latched digital output |
| dac0_o | output | 16 | Channel 0 output code |
| dac1_o | output | 16 | Channel 1 output code |

## Verification
The bench runs two kinds of sequences against a byte-level model and compares it after every access.

One sequence writes a low byte alone and then reads in per-channel mode. A design that loaded on every byte write, or on reads regardless of mode, would move an output too early. Another sequence writes both channels in grouped mode and then reads each of the eight offsets. A design that loaded on the high-byte write, or decoded only part of the window for the load, would show a stale or torn code. The bench also sweeps reads of every offset for zero data and of the input port for live values. A design that let holding contents leak onto the bus, or registered the inputs, would be caught by this sweep.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;
  localparam int BYTE_W       = 8;
  localparam int ADDR_W       = 3;
  localparam int NUM_CH       = 2;
  localparam int CH_BYTES     = 2;
  localparam int DAC_W        = BYTE_W * CH_BYTES;
  localparam int DIO_OFS      = 3;
  localparam int DAC_BASE_OFS = 4;
endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode #(
  parameter int ADDR_W       = 3,
  parameter int NUM_CH       = 2,
  parameter int CH_BYTES     = 2,
  parameter int DIO_OFS      = 3,
  parameter int DAC_BASE_OFS = 4
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_i,
  input  logic                       rd_i,
  output logic                       dio_we_o,
  output logic                       dio_re_o,
  output logic [NUM_CH*CH_BYTES-1:0] byte_we_o,
  output logic                       any_rd_o
);
  localparam int NUM_BYTES = NUM_CH * CH_BYTES;

  assign dio_we_o = wr_i && (addr_i == ADDR_W'(DIO_OFS));
  assign dio_re_o = rd_i && (addr_i == ADDR_W'(DIO_OFS));
  // every offset of the window counts as a load-triggering read
  assign any_rd_o = rd_i;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte_dec
    assign byte_we_o[i] = wr_i && (addr_i == ADDR_W'(DAC_BASE_OFS + i));
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int BYTE_W   = 8,
  parameter int CH_BYTES = 2,
  localparam int DAC_W   = BYTE_W * CH_BYTES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CH_BYTES-1:0] byte_we_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic                indiv_mode_i,
  input  logic                sim_load_i,
  output logic [DAC_W-1:0]    dac_o
);
  logic [DAC_W-1:0] hold_q;
  logic             indiv_load;

  assign indiv_load = byte_we_i[CH_BYTES-1] && indiv_mode_i;

  for (genvar b = 0; b < CH_BYTES; b++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           hold_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (byte_we_i[b]) hold_q[b*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end

  // top byte comes straight from the bus so it lands with its own write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         dac_o <= '0;
    else if (indiv_load) dac_o <= {wdata_i, hold_q[DAC_W-BYTE_W-1:0]};
    else if (sim_load_i) dac_o <= hold_q;
  end

  assert_indiv_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_we_i[CH_BYTES-1] && indiv_mode_i) |=>
      (dac_o == {$past(wdata_i), $past(hold_q[DAC_W-BYTE_W-1:0])}));

  assert_sim_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sim_load_i && !byte_we_i[CH_BYTES-1]) |=> (dac_o == $past(hold_q)));

  assert_no_stray_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sim_load_i && !(byte_we_i[CH_BYTES-1] && indiv_mode_i)) |=> $stable(dac_o));
endmodule

// File: rtl/dio_port.sv
module dio_port #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] din_i,
  output logic [BYTE_W-1:0] dout_o,
  output logic [BYTE_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_o <= '0;
    else if (we_i) dout_o <= wdata_i;
  end

  // inputs pass through unregistered
  assign rdata_o = re_i ? din_i : '0;

  assert_dout_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (dout_o == $past(wdata_i)));

  assert_dout_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(dout_o));
endmodule

// File: rtl/dual_dac_bus_regs.sv
module dual_dac_bus_regs
  import dac_regs_pkg::*;
#(
  parameter int P_BYTE_W   = BYTE_W,
  parameter int P_ADDR_W   = ADDR_W,
  parameter int P_CH_BYTES = CH_BYTES,
  parameter int P_DIO_OFS  = DIO_OFS,
  parameter int P_DAC_BASE = DAC_BASE_OFS,
  localparam int P_NUM_CH  = 2,
  localparam int P_DAC_W   = P_BYTE_W * P_CH_BYTES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [P_ADDR_W-1:0] addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [P_BYTE_W-1:0] wdata_i,
  output logic [P_BYTE_W-1:0] rdata_o,
  input  logic                sim_mode_i,
  input  logic [P_BYTE_W-1:0] din_i,
  output logic [P_BYTE_W-1:0] dout_o,
  output logic [P_DAC_W-1:0]  dac0_o,
  output logic [P_DAC_W-1:0]  dac1_o
);
  logic                           dio_we, dio_re, any_rd, sim_load;
  logic [P_NUM_CH*P_CH_BYTES-1:0] byte_we;
  logic [P_DAC_W-1:0]             dac_q [P_NUM_CH];

  dac_bus_decode #(
    .ADDR_W(P_ADDR_W), .NUM_CH(P_NUM_CH), .CH_BYTES(P_CH_BYTES),
    .DIO_OFS(P_DIO_OFS), .DAC_BASE_OFS(P_DAC_BASE)
  ) u_decode (
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .dio_we_o(dio_we), .dio_re_o(dio_re),
    .byte_we_o(byte_we), .any_rd_o(any_rd)
  );

  assign sim_load = any_rd && sim_mode_i;

  for (genvar c = 0; c < P_NUM_CH; c++) begin : g_ch
    dac_channel #(.BYTE_W(P_BYTE_W), .CH_BYTES(P_CH_BYTES)) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .byte_we_i(byte_we[c*P_CH_BYTES +: P_CH_BYTES]),
      .wdata_i(wdata_i),
      .indiv_mode_i(!sim_mode_i),
      .sim_load_i(sim_load),
      .dac_o(dac_q[c])
    );
  end

  assign dac0_o = dac_q[0];
  assign dac1_o = dac_q[1];

  dio_port #(.BYTE_W(P_BYTE_W)) u_dio (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(dio_we), .re_i(dio_re),
    .wdata_i(wdata_i), .din_i(din_i),
    .dout_o(dout_o), .rdata_o(rdata_o)
  );

  assert_live_input_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == P_ADDR_W'(P_DIO_OFS)) |-> (rdata_o == din_i));

  assert_zero_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != P_ADDR_W'(P_DIO_OFS)) |-> (rdata_o == '0));

  assert_read_no_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !sim_mode_i) |=> ($stable(dac0_o) && $stable(dac1_o)));

  assert_low_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && (addr_i == P_ADDR_W'(P_DAC_BASE) ||
                      addr_i == P_ADDR_W'(P_DAC_BASE + P_CH_BYTES)))
      |=> ($stable(dac0_o) && $stable(dac1_o)));
endmodule

// File: tb/dual_dac_bus_regs_bench.sv
module dual_dac_bus_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, mode = 1'b0;
  logic [7:0]  wdata = '0, din = '0;
  logic [7:0]  rdata, dout;
  logic [15:0] dac0, dac1;

  int checks = 0, errors = 0;
  logic [15:0] m_hold [2];
  logic [15:0] m_out  [2];
  logic [7:0]  m_dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_bus_regs u_dual_dac_bus_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sim_mode_i(mode), .din_i(din),
    .dout_o(dout), .dac0_o(dac0), .dac1_o(dac1)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " dac0"}, dac0, m_out[0]);
    chk({tag, " dac1"}, dac1, m_out[1]);
    chk({tag, " dout"}, {8'h00, dout}, {8'h00, m_dout});
  endtask

  task automatic do_wr(input string tag, input logic [2:0] a, input logic [7:0] d);
    int idx;
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (a == 3'd3) m_dout = d;
    else if (a >= 3'd4) begin
      idx = int'(a) - 4;
      if (idx % 2 == 0) m_hold[idx/2][7:0] = d;
      else begin
        m_hold[idx/2][15:8] = d;
        if (!mode) m_out[idx/2] = m_hold[idx/2];
      end
    end
    chk_state(tag);
  endtask

  task automatic do_rd(input string tag, input logic [2:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    chk({tag, " rdata"}, {8'h00, rdata}, {8'h00, (a == 3'd3) ? din : 8'h00});
    @(negedge clk);
    rd = 1'b0;
    if (mode) begin
      m_out[0] = m_hold[0];
      m_out[1] = m_hold[1];
    end
    chk_state(tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_hold[0] = '0; m_hold[1] = '0; m_out[0] = '0; m_out[1] = '0; m_dout = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 reset");

    // R9: every offset except the port reads zero
    for (int a = 0; a < 8; a++)
      if (a != 3) do_rd("R9 zero read", 3'(a));

    // R8: live input sweep
    for (int i = 0; i < 16; i++) begin
      din = 8'(i * 17) ^ 8'h5A;
      do_rd("R8 live input", 3'd3);
    end

    // R7: latched output, other offsets leave it alone
    for (int i = 0; i < 8; i++) do_wr("R7 dout write", 3'd3, (8'h01 << i) ^ 8'(i));
    for (int a = 0; a < 3; a++) do_wr("R7 dout hold", 3'(a), 8'hFF);

    // per-channel mode
    mode = 1'b0;
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 6; k++) begin
        do_wr("R2 low only", 3'(4 + 2*c), 8'(k * 37 + c));
        do_wr("R3 high loads", 3'(5 + 2*c), 8'(k * 53 + 128 * c));
      end
    do_wr("R2 low only", 3'd4, 8'hAA);
    do_wr("R2 low only", 3'd6, 8'h55);
    do_rd("R6 read no load", 3'd1);
    do_rd("R6 read no load", 3'd7);

    // grouped mode
    mode = 1'b1;
    for (int k = 0; k < 8; k++) begin
      do_wr("R4 deferred", 3'd4, 8'(k * 29 + 3));
      do_wr("R4 deferred", 3'd5, 8'(k * 31 + 7));
      do_wr("R4 deferred", 3'd6, 8'(k * 41 + 11));
      do_wr("R4 deferred", 3'd7, 8'(k * 43 + 13));
      do_rd("R5 grouped load", 3'(k));
    end
    do_wr("R4 deferred", 3'd5, 8'h80);
    mode = 1'b0;
    @(negedge clk);
    chk_state("R4 mode change without access");
    do_rd("R6 read no load", 3'd0);

    finish_run();
  end
endmodule